// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a word-addressed memory that two (or, by parameter, more) requesters share. Each cycle a fixed-priority arbiter accepts at most one request. The operations are a plain load, a plain store, a load-linked and a store-conditional. A load-linked returns the addressed word and records a reservation on that word for the requester that issued it. A later store-conditional from the same requester to the same word writes the memory only if no write has reached that word in the meantime. It reports 1 when the write happened and 0 when it was suppressed.

Software uses the pair to build atomic primitives such as swap or test-and-set. It issues the load-linked, computes the new value and tries the store-conditional, and it retries the whole sequence when the result is 0. The answer to every accepted request appears one cycle after the grant. The answer carries the winning requester's index and either the read word or the success flag.

Top module: `resv_monitor`

## Requirements
- R1: After reset no response is pending, no requester holds a reservation, and every memory word reads as zero.
- R2: The operation code is 2 bits per requester: 0 load, 1 store, 2 load-linked, 3 store-conditional. A load returns the addressed word. A store writes its data and answers with data zero.
- R3: At most one request is granted per cycle. A grant goes only to a requester with its valid bit set, and the lowest-numbered valid requester always wins.
- R4: A response (`rsp_valid` high, `rsp_id` equal to the winner's index) appears in exactly the cycle after a grant, and never in a cycle that follows a cycle with no grant.
- R5: A load-linked returns the addressed word and sets its requester's reservation on that address. A later load-linked from the same requester replaces the reservation.
- R6: A store-conditional whose requester holds a reservation on the same address writes its data and answers 1 in bit 0, with all other bits zero.
- R7: A store-conditional whose requester holds no reservation, or holds one on a different address, leaves memory unchanged and answers 0.
- R8: Any write to an address, whether a store or a successful store-conditional from any requester, clears every reservation held on that address. Writes to other addresses leave reservations intact.
- R9: A store-conditional clears its own requester's reservation whether it succeeds or fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | 2*NREQ | Operation code per requester, requester i in bits [2i+1:2i] |
| req_addr | input | ADDR_W*NREQ | Word address per requester |
| req_wdata | input | DATA_W*NREQ | Write data per requester |
| req_grant | output | NREQ | One-hot grant for this cycle's accepted request |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | IDX_W | Index of the requester being answered |
| rsp_data | output | DATA_W | Read word, or store-conditional flag in bit 0 |

## Verification
The hardest case to reach is a reservation lost to another requester's write in the narrow window between a load-linked and its store-conditional. The write may be a plain store or a winning store-conditional that clears the loser's reservation. Random traffic on the two requesters is confined to four addresses with a mix weighted toward linked operations, so that overlapping reservations and conflicting writes occur often. Directed sequences also force the clear-by-store, clear-by-other-SC, replaced-reservation, repeated-SC and simultaneous-request orderings.

// File: rtl/resv_pkg.sv
package resv_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_LINK  = 2'd2,
      OP_COND  = 2'd3
   } op_e;
endpackage

// File: rtl/resv_arbiter.sv
// Fixed-priority pick: lowest index among valid requests.
module resv_arbiter #(
   parameter int NREQ  = 2,
   parameter int IDX_W = 1
) (
   input  logic [NREQ-1:0]  req_i,
   output logic [NREQ-1:0]  gnt_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   always_comb begin
      gnt_o = '0;
      idx_o = '0;
      for (int i = NREQ-1; i >= 0; i--) begin
         if (req_i[i]) begin
            gnt_o    = '0;
            gnt_o[i] = 1'b1;
            idx_o    = IDX_W'(i);
         end
      end
      any_o = |req_i;
   end
endmodule

// File: rtl/resv_slot.sv
// One requester's reservation: valid bit plus word address.
module resv_slot #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [ADDR_W-1:0] set_addr_i,
   input  logic              clr_own_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [ADDR_W-1:0] probe_addr_i,
   output logic              vld_o,
   output logic              hit_o
);
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         addr_q <= '0;
      end else if (set_i) begin
         vld_o  <= 1'b1;
         addr_q <= set_addr_i;
      end else if (clr_own_i || (wr_i && vld_o && addr_q == wr_addr_i)) begin
         vld_o  <= 1'b0;
      end
   end

   assign hit_o = vld_o && (addr_q == probe_addr_i);
endmodule

// File: rtl/resv_store.sv
// Word storage, registered read port, write on the same edge.
module resv_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         rdata_o <= '0;
      end else begin
         rdata_o <= mem_q[addr_i];
         if (we_i) mem_q[addr_i] <= wdata_i;
      end
   end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
   import resv_pkg::*;
#(
   parameter int NREQ   = 2,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NREQ-1:0]          req_valid,
   input  logic [2*NREQ-1:0]        req_op,
   input  logic [ADDR_W*NREQ-1:0]   req_addr,
   input  logic [DATA_W*NREQ-1:0]   req_wdata,
   output logic [NREQ-1:0]          req_grant,
   output logic                     rsp_valid,
   output logic [IDX_W-1:0]         rsp_id,
   output logic [DATA_W-1:0]        rsp_data
);
   generate
      if (NREQ < 2) begin : g_bad_nreq
         $error("resv_monitor: NREQ must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("resv_monitor: ADDR_W must be in 1..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("resv_monitor: DATA_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]  win_idx;
   logic              win_any;
   op_e               win_op;
   logic [ADDR_W-1:0] win_addr;
   logic [DATA_W-1:0] win_wdata;
   logic [NREQ-1:0]   slot_vld;
   logic [NREQ-1:0]   slot_hit;
   logic              cond_ok;
   logic              mem_we;
   logic [DATA_W-1:0] mem_rdata;

   resv_arbiter #(.NREQ(NREQ), .IDX_W(IDX_W)) u_arb (
      .req_i (req_valid),
      .gnt_o (req_grant),
      .idx_o (win_idx),
      .any_o (win_any)
   );

   assign win_op    = op_e'(req_op[win_idx*2 +: 2]);
   assign win_addr  = req_addr[win_idx*ADDR_W +: ADDR_W];
   assign win_wdata = req_wdata[win_idx*DATA_W +: DATA_W];
   assign cond_ok   = win_any && (win_op == OP_COND) && slot_hit[win_idx];
   assign mem_we    = win_any && ((win_op == OP_STORE) || cond_ok);

   generate
      for (genvar g = 0; g < NREQ; g++) begin : g_slot
         resv_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .set_i        (req_grant[g] && (win_op == OP_LINK)),
            .set_addr_i   (win_addr),
            .clr_own_i    (req_grant[g] && (win_op == OP_COND)),
            .wr_i         (mem_we),
            .wr_addr_i    (win_addr),
            .probe_addr_i (win_addr),
            .vld_o        (slot_vld[g]),
            .hit_o        (slot_hit[g])
         );
      end
   endgenerate

   resv_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .addr_i  (win_addr),
      .wdata_i (win_wdata),
      .rdata_o (mem_rdata)
   );

   op_e  kind_q;
   logic ok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
         kind_q    <= OP_LOAD;
         ok_q      <= 1'b0;
      end else begin
         rsp_valid <= win_any;
         rsp_id    <= win_idx;
         kind_q    <= win_op;
         ok_q      <= cond_ok;
      end
   end

   always_comb begin
      if (kind_q == OP_LOAD || kind_q == OP_LINK) rsp_data = mem_rdata;
      else rsp_data = {{(DATA_W-1){1'b0}}, (kind_q == OP_COND) && ok_q};
   end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk
   import resv_pkg::*;
#(
   parameter int NREQ   = 2,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NREQ-1:0]    req_valid,
   input logic [2*NREQ-1:0]  req_op,
   input logic [NREQ-1:0]    req_grant,
   input logic               rsp_valid,
   input logic [IDX_W-1:0]   rsp_id,
   input logic [DATA_W-1:0]  rsp_data,
   input logic [NREQ-1:0]    slot_vld
);
   a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_grant));
   a_r3_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant & ~req_valid) == '0);
   a_r3_req0_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[0] |-> req_grant[0]);
   a_r4_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_grant) |=> rsp_valid);
   a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_grant) |=> !rsp_valid);
   a_r4_rsp_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[0] |=> (rsp_id == '0));
   a_r5_link_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant[0] && req_op[1:0] == OP_LINK) |=> slot_vld[0]);
   a_r7_no_resv_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant[0] && req_op[1:0] == OP_COND && !slot_vld[0]) |=> (rsp_data == '0));
   a_r9_cond_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant[0] && req_op[1:0] == OP_COND) |=> !slot_vld[0]);
endmodule

bind resv_monitor resv_monitor_chk #(
   .NREQ(NREQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb;
   localparam int AW = 6;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    req_valid = '0;
   logic [3:0]    req_op = '0;
   logic [2*AW-1:0] req_addr = '0;
   logic [2*DW-1:0] req_wdata = '0;
   logic [1:0]    req_grant;
   logic          rsp_valid;
   logic [0:0]    rsp_id;
   logic [DW-1:0] rsp_data;

   resv_monitor #(.NREQ(2), .ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // bench model
   logic [DW-1:0] m_mem [64];
   bit            m_rv [2];
   logic [AW-1:0] m_ra [2];
   bit            p_valid = 0;
   int            p_id;
   logic [DW-1:0] p_data;
   string         p_tag;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_rsp();
      if (p_valid) begin
         chk(rsp_valid == 1'b1, "R4", "rsp_valid", rsp_valid, 1);
         chk(rsp_id == p_id[0], "R4", "rsp_id", rsp_id, p_id);
         chk(rsp_data == p_data, p_tag, "rsp_data", rsp_data, p_data);
      end else begin
         chk(rsp_valid == 1'b0, "R4", "idle rsp_valid", rsp_valid, 0);
      end
   endtask

   function automatic void clear_match(input logic [AW-1:0] a);
      for (int k = 0; k < 2; k++) if (m_rv[k] && m_ra[k] == a) m_rv[k] = 0;
   endfunction

   task automatic step(input bit v0, input logic [1:0] o0, input logic [AW-1:0] a0,
                       input logic [DW-1:0] d0, input bit v1, input logic [1:0] o1,
                       input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                       input string tag);
      int w;
      logic [1:0] op;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      bit ok;
      @(negedge clk);
      check_rsp();
      req_valid = {v1, v0};
      req_op    = {o1, o0};
      req_addr  = {a1, a0};
      req_wdata = {d1, d0};
      #1;
      w = v0 ? 0 : (v1 ? 1 : -1);
      chk(req_grant == (w < 0 ? 2'b00 : (w == 0 ? 2'b01 : 2'b10)), "R3", "grant",
          req_grant, (w < 0 ? 0 : (w == 0 ? 1 : 2)));
      p_valid = (w >= 0);
      if (w >= 0) begin
         op = (w == 0) ? o0 : o1;
         a  = (w == 0) ? a0 : a1;
         d  = (w == 0) ? d0 : d1;
         p_id = w;
         case (op)
            2'd0: begin p_data = m_mem[a]; p_tag = "R2"; end
            2'd1: begin p_data = '0; m_mem[a] = d; clear_match(a); p_tag = "R2"; end
            2'd2: begin p_data = m_mem[a]; m_rv[w] = 1; m_ra[w] = a; p_tag = "R5"; end
            default: begin
               ok = m_rv[w] && m_ra[w] == a;
               p_data = ok ? 1 : 0;
               p_tag  = ok ? "R6" : "R7";
               if (ok) begin m_mem[a] = d; clear_match(a); end
               m_rv[w] = 0;
            end
         endcase
         if (tag != "") p_tag = tag;
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   initial begin
      #3_000_000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1a7c));
      for (int i = 0; i < 64; i++) m_mem[i] = '0;
      m_rv[0] = 0; m_rv[1] = 0; m_ra[0] = '0; m_ra[1] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
      chk(req_grant == 0, "R1", "grant after reset", req_grant, 0);
      step(1, 0, 6'd5, 0, 0, 0, 0, 0, "R1");          // load of cleared memory
      step(1, 3, 6'd5, 32'hAA, 0, 0, 0, 0, "R1");      // SC with no reservation after reset
      step(1, 0, 6'd5, 0, 0, 0, 0, 0, "R7");           // memory unchanged
      // R8: store from requester 1 kills requester 0's reservation
      step(1, 2, 6'd1, 0, 0, 0, 0, 0, "");
      step(0, 0, 0, 0, 1, 1, 6'd1, 32'h11, "");
      step(1, 3, 6'd1, 32'h22, 0, 0, 0, 0, "R8");
      // R8: write elsewhere keeps reservation
      step(1, 2, 6'd2, 0, 0, 0, 0, 0, "");
      step(0, 0, 0, 0, 1, 1, 6'd3, 32'h33, "");
      step(1, 3, 6'd2, 32'h44, 0, 0, 0, 0, "R8");
      // R8: successful SC by requester 1 clears requester 0's reservation
      step(1, 2, 6'd4, 0, 0, 0, 0, 0, "");
      step(0, 0, 0, 0, 1, 2, 6'd4, 0, "");
      step(0, 0, 0, 0, 1, 3, 6'd4, 32'h55, "R6");
      step(1, 3, 6'd4, 32'h66, 0, 0, 0, 0, "R8");
      step(1, 0, 6'd4, 0, 0, 0, 0, 0, "R8");
      // R5: replaced reservation, SC to old address fails (R7)
      step(1, 2, 6'd6, 0, 0, 0, 0, 0, "");
      step(1, 2, 6'd7, 0, 0, 0, 0, 0, "R5");
      step(1, 3, 6'd6, 32'h77, 0, 0, 0, 0, "R7");
      // R9: second SC after a success fails
      step(1, 2, 6'd8, 0, 0, 0, 0, 0, "");
      step(1, 3, 6'd8, 32'h88, 0, 0, 0, 0, "R6");
      step(1, 3, 6'd8, 32'h99, 0, 0, 0, 0, "R9");
      // R9: failed SC (wrong address) still drops reservation
      step(1, 2, 6'd9, 0, 0, 0, 0, 0, "");
      step(1, 3, 6'd10, 32'h1, 0, 0, 0, 0, "R7");
      step(1, 3, 6'd9, 32'h2, 0, 0, 0, 0, "R9");
      // R3: simultaneous requests, requester 0 wins
      step(1, 2, 6'd11, 0, 1, 2, 6'd11, 0, "R3");
      step(0, 0, 0, 0, 1, 3, 6'd11, 32'h3, "R7");
      idle();
      // random traffic on few addresses
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] o0, o1;
         o0 = ($urandom % 4 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
         o1 = ($urandom % 4 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
         step(1'($urandom % 3 == 0), o0, 6'($urandom % 4), $urandom,
              1'($urandom % 3 != 2), o1, 6'($urandom % 4), $urandom, "");
      end
      idle();
      idle();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule